// File: doc/BRIEF.md
# Serial Peripheral Master with Bus Registers

This block lets a processor on a 50 MHz register bus talk to one serial peripheral. Software writes a 16-bit word into the transmit register. The block then pulls its select line low and holds the serial clock low for a fixed setup time. After that it clocks the word out, most significant bit first, and captures the answering word from the input line at the same time. When the word is finished, the block stores the received word and updates its status flags. It raises an interrupt line if any status flag that has its enable bit set is active.

The bus uses word addresses: 0 is receive data (read), 1 is transmit data (write), 2 is status, 3 is control, 4 is reserved and reads zero, 5 is the select enable, and 6 is the end-of-packet compare value. A word written while a transfer is running is held and sent right after the current word, without releasing select. The serial format is fixed. The clock idles low, the output bit changes on the falling clock edge, and the input bit is sampled on the rising edge. Each clock half lasts `HALF_DIV` system cycles, and the setup time is `SETUP_CYC` cycles.

Top module: `sspi_master`

## Requirements
- R1: After reset, ss_n is 1, sclk is 0, irq is 0, the receive word reads 0, and status reads 0x06 (shifter-idle bit 1 and transmit-ready bit 2 set).
- R2: If select-enable bit 0 is set, ss_n is low from the start of a word until its last clock half ends. Control bit 5 (force) holds ss_n low while the block is idle. With select-enable clear, ss_n stays high all the time.
- R3: The first rising sclk edge of a word comes exactly SETUP_CYC cycles after the transfer starts, and sclk stays low during that time.
- R4: Each sclk half lasts HALF_DIV cycles, and each word has exactly 16 rising edges.
- R5: mosi carries the transmit word MSB first and changes only on falling sclk edges. miso is sampled on rising edges.
- R6: Writing transmit data while idle starts a word. Writing it during a transfer clears status bit 2 until that word is taken, and the held word follows without ss_n rising in between.
- R7: A finished word is placed in the receive register and sets receive-ready (status bit 3). Reading the receive register clears that bit.
- R8: If a word finishes while receive-ready is still set, overrun (status bit 0) is set, and the receive register holds the newer word.
- R9: End-of-packet (status bit 4) is set when the sent word or the received word equals the compare register. Any write to status clears bits 0 and 4 and leaves the other bits as they are.
- R10: irq is high exactly when a status bit is set and the control bit at the same position (bits 0 to 4) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| irq | output | 1 | Interrupt request |
| ss_n | output | 1 | Slave select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that each bus access is a single-cycle strobe and that reset is held for at least one clock. They also assume that miso only changes well away from the clock edges where the block samples it. The bench follows these rules in three ways. Its bus tasks drive each access for exactly one cycle between falling edges. Its slave model updates miso half a system cycle after it sees sclk fall. It releases reset on a falling edge.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [2:0] {
    A_RX   = 3'd0,
    A_TX   = 3'd1,
    A_STAT = 3'd2,
    A_CTRL = 3'd3,
    A_RSVD = 3'd4,
    A_SSEL = 3'd5,
    A_EOP  = 3'd6,
    A_NONE = 3'd7
  } reg_addr_e;

  localparam int ST_ROE   = 0;
  localparam int ST_TMT   = 1;
  localparam int ST_TRDY  = 2;
  localparam int ST_RRDY  = 3;
  localparam int ST_EOP   = 4;
  localparam int NSTAT    = 5;
  localparam int CT_FORCE = NSTAT;
  localparam int CTW      = NSTAT + 1;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_HIGH, PH_LOW} phase_e;

  function automatic int unsigned phase_len(phase_e p, int unsigned setup,
                                            int unsigned half);
    return (p == PH_SETUP) ? setup : half;
  endfunction

  function automatic logic irq_pending(logic [NSTAT-1:0] st, logic [NSTAT-1:0] ie);
    return |(st & ie);
  endfunction

endpackage

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int DW       = 16,
  parameter int HALF_DIV = 100,
  parameter int SETUP_CYC = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          have_word,
  input  logic [DW-1:0] tx_word,
  input  logic          miso,
  output logic          take,
  output logic          busy,
  output logic          sclk,
  output logic          mosi,
  output logic          done,
  output logic          rise_evt,
  output logic          fall_evt,
  output logic [DW-1:0] rx_word,
  output logic [DW-1:0] sent_word
);
  localparam int MAXL = (HALF_DIV > SETUP_CYC) ? HALF_DIV : SETUP_CYC;
  localparam int CW   = $clog2(MAXL + 1);
  localparam int BW   = $clog2(DW);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bit_i;
  logic [DW-1:0] tx_sh;
  logic [DW-1:0] rx_sh;
  logic          phase_end;
  logic          last_bit;

  assign phase_end = (32'(cnt) == phase_len(phase, SETUP_CYC, HALF_DIV) - 1);
  assign last_bit  = (bit_i == BW'(DW - 1));
  assign done      = (phase == PH_LOW) && phase_end && last_bit;
  assign take      = have_word && ((phase == PH_IDLE) || done);
  assign rise_evt  = phase_end && ((phase == PH_SETUP) ||
                                   ((phase == PH_LOW) && !last_bit));
  assign fall_evt  = (phase == PH_HIGH) && phase_end;
  assign busy      = (phase != PH_IDLE);
  assign mosi      = tx_sh[DW-1];
  assign rx_word   = rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      bit_i     <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sent_word <= '0;
      sclk      <= 1'b0;
    end else begin
      if (take) begin
        phase     <= PH_SETUP;
        cnt       <= '0;
        bit_i     <= '0;
        tx_sh     <= tx_word;
        sent_word <= tx_word;
      end else if (done) begin
        phase <= PH_IDLE;
        cnt   <= '0;
      end else if (rise_evt) begin
        phase <= PH_HIGH;
        cnt   <= '0;
        sclk  <= 1'b1;
        rx_sh <= {rx_sh[DW-2:0], miso};
        if (phase == PH_LOW) bit_i <= bit_i + 1'b1;
      end else if (fall_evt) begin
        phase <= PH_LOW;
        cnt   <= '0;
        sclk  <= 1'b0;
        if (!last_bit) tx_sh <= {tx_sh[DW-2:0], 1'b0};
      end else if (phase != PH_IDLE) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          take,
  input  logic          done,
  input  logic          busy,
  input  logic [DW-1:0] rx_word,
  input  logic [DW-1:0] sent_word,
  output logic          tx_full,
  output logic [DW-1:0] tx_hold,
  output logic          ssel_en,
  output logic          force_sel,
  output logic          rrdy,
  output logic          irq
);
  logic [DW-1:0]    rx_reg;
  logic [DW-1:0]    eop_reg;
  logic [CTW-1:0]   ctrl;
  logic             roe;
  logic             eop_flag;
  logic [NSTAT-1:0] status;
  logic             wr_tx, wr_stat, wr_ctrl, wr_ssel, wr_eop, rd_rx, hit;

  function automatic logic addr_is(logic [2:0] a, reg_addr_e r);
    return a == 3'(r);
  endfunction

  assign wr_tx   = bus_sel && bus_wr && addr_is(bus_addr, A_TX);
  assign wr_stat = bus_sel && bus_wr && addr_is(bus_addr, A_STAT);
  assign wr_ctrl = bus_sel && bus_wr && addr_is(bus_addr, A_CTRL);
  assign wr_ssel = bus_sel && bus_wr && addr_is(bus_addr, A_SSEL);
  assign wr_eop  = bus_sel && bus_wr && addr_is(bus_addr, A_EOP);
  assign rd_rx   = bus_sel && bus_rd && addr_is(bus_addr, A_RX);
  assign hit     = (sent_word == eop_reg) || (rx_word == eop_reg);

  always_comb begin
    status          = '0;
    status[ST_ROE]  = roe;
    status[ST_TMT]  = !busy;
    status[ST_TRDY] = !tx_full;
    status[ST_RRDY] = rrdy;
    status[ST_EOP]  = eop_flag;
  end

  assign force_sel = ctrl[CT_FORCE];
  assign irq       = irq_pending(status, ctrl[NSTAT-1:0]);

  always_comb begin
    unique case (bus_addr)
      3'(A_RX):   bus_rdata = rx_reg;
      3'(A_STAT): bus_rdata = {{(DW-NSTAT){1'b0}}, status};
      3'(A_CTRL): bus_rdata = {{(DW-CTW){1'b0}}, ctrl};
      3'(A_SSEL): bus_rdata = {{(DW-1){1'b0}}, ssel_en};
      3'(A_EOP):  bus_rdata = eop_reg;
      default:    bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_reg   <= '0;
      eop_reg  <= '0;
      tx_hold  <= '0;
      tx_full  <= 1'b0;
      ctrl     <= '0;
      ssel_en  <= 1'b0;
      rrdy     <= 1'b0;
      roe      <= 1'b0;
      eop_flag <= 1'b0;
    end else begin
      if (wr_tx) begin
        tx_hold <= bus_wdata;
        tx_full <= 1'b1;
      end else if (take) begin
        tx_full <= 1'b0;
      end
      if (wr_ctrl) ctrl    <= bus_wdata[CTW-1:0];
      if (wr_ssel) ssel_en <= bus_wdata[0];
      if (wr_eop)  eop_reg <= bus_wdata;

      if (done) begin
        rx_reg <= rx_word;
        rrdy   <= 1'b1;
      end else if (rd_rx) begin
        rrdy <= 1'b0;
      end

      if (done && rrdy && !rd_rx) roe <= 1'b1;
      else if (wr_stat)           roe <= 1'b0;

      if (done && hit)   eop_flag <= 1'b1;
      else if (wr_stat)  eop_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/sspi_master.sv
module sspi_master
  import spim_pkg::*;
#(
  parameter int DW        = 16,
  parameter int HALF_DIV  = 100,
  parameter int SETUP_CYC = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          ss_n,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  logic          take, busy, word_done, rise_evt, fall_evt;
  logic          tx_full, ssel_en, force_sel, rrdy;
  logic [DW-1:0] tx_hold, rx_word, sent_word;

  spim_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .take      (take),
    .done      (word_done),
    .busy      (busy),
    .rx_word   (rx_word),
    .sent_word (sent_word),
    .tx_full   (tx_full),
    .tx_hold   (tx_hold),
    .ssel_en   (ssel_en),
    .force_sel (force_sel),
    .rrdy      (rrdy),
    .irq       (irq)
  );

  spim_shifter #(.DW(DW), .HALF_DIV(HALF_DIV), .SETUP_CYC(SETUP_CYC)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .have_word (tx_full),
    .tx_word   (tx_hold),
    .miso      (miso),
    .take      (take),
    .busy      (busy),
    .sclk      (sclk),
    .mosi      (mosi),
    .done      (word_done),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .rx_word   (rx_word),
    .sent_word (sent_word)
  );

  assign ss_n = !(ssel_en && (busy || force_sel));

endmodule

// File: rtl/spim_checks.sv
module spim_checks #(
  parameter int HALF_DIV  = 100,
  parameter int SETUP_CYC = 100
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic ss_n,
  input logic mosi,
  input logic busy,
  input logic word_done,
  input logic rise_evt,
  input logic rrdy,
  input logic irq,
  input logic bus_sel,
  input logic bus_wr,
  input logic bus_rd
);
  logic [31:0] sel_len;
  logic [31:0] hi_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_len <= '0;
      hi_len  <= '0;
    end else begin
      sel_len <= ss_n ? '0 : ((&sel_len) ? sel_len : sel_len + 1);
      hi_len  <= sclk ? hi_len + 1 : '0;
    end
  end

  assert_sclk_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> busy);

  assert_setup_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && !ss_n) |-> (sel_len >= 32'(SETUP_CYC)));

  assert_high_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_len == 32'(HALF_DIV)));

  assert_mosi_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_rise_matches_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> sclk);

  assert_rrdy_from_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rrdy) |-> $past(word_done));

  assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(word_done));

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(word_done) || $past(bus_sel && (bus_wr || bus_rd)) ||
                    $past(busy) != busy));

endmodule

bind sspi_master spim_checks #(.HALF_DIV(HALF_DIV), .SETUP_CYC(SETUP_CYC)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk      (sclk),
  .ss_n      (ss_n),
  .mosi      (mosi),
  .busy      (busy),
  .word_done (word_done),
  .rise_evt  (rise_evt),
  .rrdy      (rrdy),
  .irq       (irq),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd)
);

// File: tb/test_sspi_master.sv
module test_sspi_master;
  localparam int CLK_PERIOD = 20;
  localparam int HALF  = 100;
  localparam int SETUP = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, ss_n, sclk, mosi, miso;

  int checks = 0;
  int fails  = 0;

  logic [15:0] slv_word = 16'hA55A;
  logic [3:0]  idx = '0;
  logic [31:0] mosi_cap = '0;
  int          cyc = 0, t_sel = 0, t_rise = 0;
  int          rises = 0, ss_rises = 0, ss_low_cyc = 0;
  int          setup_meas = -1, period_meas = -1;
  logic        prev_ss = 1'b1, prev_sclk = 1'b0, pend = 1'b0;

  assign miso = slv_word[4'd15 - idx];

  sspi_master #(.DW(16), .HALF_DIV(HALF), .SETUP_CYC(SETUP)) i_sspi_master (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .ss_n(ss_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!ss_n) ss_low_cyc <= ss_low_cyc + 1;
    if (prev_ss && !ss_n) begin t_sel <= cyc; pend <= 1'b1; end
    if (!prev_ss && ss_n) ss_rises <= ss_rises + 1;
    if (!prev_sclk && sclk) begin
      rises    <= rises + 1;
      mosi_cap <= {mosi_cap[30:0], mosi};
      if (pend) begin setup_meas <= cyc - t_sel; pend <= 1'b0; end
      else period_meas <= cyc - t_rise;
      t_rise <= cyc;
    end
    if (prev_sclk && !sclk) idx <= idx + 1'b1;
    prev_ss   <= ss_n;
    prev_sclk <= sclk;
  end

  function automatic logic [15:0] exp_status(logic roe, logic rrdy, logic eop);
    return {11'd0, eop, rrdy, 1'b1, 1'b1, roe};
  endfunction

  function automatic logic exp_eop(logic [15:0] tx, logic [15:0] rx, logic [15:0] e);
    return (tx == e) || (rx == e);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd2, s);
      if (s[1] && s[2]) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] a, b, e;
    int r0, s0, l0;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ss_n", {31'd0, ss_n}, 32'd1);
    chk("R1 sclk", {31'd0, sclk}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(3'd2, v); chk("R1 status", {16'd0, v}, 32'h6);
    rd(3'd0, v); chk("R1 rx", {16'd0, v}, 32'h0);

    // single word: R2 R3 R4 R5 R7
    wr(3'd5, 16'h1);
    r0 = rises; slv_word = 16'hA55A;
    wr(3'd1, 16'h3C81);
    repeat (3) @(negedge clk);
    chk("R2 ss_n low in transfer", {31'd0, ss_n}, 32'd0);
    wait_idle();
    chk("R5 mosi word", {16'd0, mosi_cap[15:0]}, 32'h3C81);
    chk("R4 rise count", rises - r0, 16);
    chk("R3 setup cycles", setup_meas, SETUP);
    chk("R4 bit period", period_meas, 2 * HALF);
    chk("R2 ss_n released", {31'd0, ss_n}, 32'd1);
    rd(3'd2, v); chk("R7 status rrdy", {16'd0, v}, {16'd0, exp_status(0, 1, 0)});
    rd(3'd0, v); chk("R7 rx word", {16'd0, v}, 32'hA55A);
    rd(3'd2, v); chk("R7 rrdy cleared", {16'd0, v}, {16'd0, exp_status(0, 0, 0)});

    // overrun: R8 and status-write clear R9
    slv_word = 16'h0F0F;
    wr(3'd1, 16'h1111); wait_idle();
    slv_word = 16'h7E01;
    wr(3'd1, 16'h2222); wait_idle();
    rd(3'd2, v); chk("R8 overrun set", {16'd0, v}, {16'd0, exp_status(1, 1, 0)});
    rd(3'd0, v); chk("R8 newest word kept", {16'd0, v}, 32'h7E01);
    wr(3'd2, 16'h0);
    rd(3'd2, v); chk("R9 write clears overrun", {16'd0, v}, {16'd0, exp_status(0, 0, 0)});

    // back-to-back: R6
    slv_word = 16'h8001; a = 16'hC3A5; b = 16'h5A0F;
    s0 = ss_rises; r0 = rises;
    wr(3'd1, a);
    repeat (20) @(negedge clk);
    wr(3'd1, b);
    rd(3'd2, v); chk("R6 trdy low while held", {31'd0, v[2]}, 32'd0);
    wait_idle();
    chk("R6 both words in order", mosi_cap, {a, b});
    chk("R6 select held between words", ss_rises - s0, 1);
    chk("R4 rise count two words", rises - r0, 32);
    rd(3'd0, v); chk("R6 rx second", {16'd0, v}, 32'h8001);
    wr(3'd2, 16'h0);

    // end-of-packet: R9
    slv_word = 16'h1234;
    wr(3'd6, 16'h1234);
    wr(3'd1, 16'h9999); wait_idle();
    rd(3'd2, v); chk("R9 eop on rx match", {16'd0, v}, {16'd0, exp_status(0, 1, 1)});
    wr(3'd2, 16'hFFFF);
    rd(3'd2, v); chk("R9 eop cleared rrdy kept", {16'd0, v}, {16'd0, exp_status(0, 1, 0)});
    rd(3'd0, v);
    wr(3'd6, 16'h4444);
    wr(3'd1, 16'h4444); wait_idle();
    rd(3'd2, v); chk("R9 eop on tx match", {31'd0, v[4]}, 32'd1);
    rd(3'd0, v); wr(3'd2, 16'h0);

    // interrupt: R10
    wr(3'd3, 16'h0008);
    chk("R10 irq low no cause", {31'd0, irq}, 32'd0);
    wr(3'd1, 16'h00FF); wait_idle();
    @(negedge clk);
    chk("R10 irq on rrdy", {31'd0, irq}, 32'd1);
    rd(3'd0, v);
    @(negedge clk);
    chk("R10 irq after read", {31'd0, irq}, 32'd0);
    wr(3'd3, 16'h0004);
    @(negedge clk);
    chk("R10 irq trdy enabled", {31'd0, irq}, 32'd1);
    wr(3'd3, 16'h0000);
    @(negedge clk);
    chk("R10 irq disabled", {31'd0, irq}, 32'd0);

    // force and select-enable: R2
    wr(3'd3, 16'h0020);
    @(negedge clk);
    chk("R2 force low", {31'd0, ss_n}, 32'd0);
    wr(3'd3, 16'h0000);
    @(negedge clk);
    chk("R2 force released", {31'd0, ss_n}, 32'd1);
    wr(3'd5, 16'h0);
    l0 = ss_low_cyc; slv_word = 16'h6B2D;
    wr(3'd1, 16'hBEEF); wait_idle();
    chk("R2 no select when disabled", ss_low_cyc - l0, 0);
    rd(3'd0, v); chk("R7 rx with select off", {16'd0, v}, 32'h6B2D);
    wr(3'd5, 16'h1);

    // random words: R5 R7 R9
    void'($urandom(32'd7));
    for (int k = 0; k < 8; k++) begin
      a = 16'($urandom);
      slv_word = 16'($urandom);
      e = (k % 3 == 0) ? slv_word : ((k % 3 == 1) ? a : 16'($urandom));
      wr(3'd6, e);
      wr(3'd1, a); wait_idle();
      chk("R5 random mosi", {16'd0, mosi_cap[15:0]}, {16'd0, a});
      rd(3'd2, v);
      chk("R9 random status", {16'd0, v},
          {16'd0, exp_status(0, 1, exp_eop(a, slv_word, e))});
      rd(3'd0, v);
      chk("R7 random rx", {16'd0, v}, {16'd0, slv_word});
      wr(3'd2, 16'h0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule